// File: doc/BRIEF.md
# Serial EEPROM Write-All Slave

This block models the slave side of a three-wire serial EEPROM (chip select, serial clock, serial data in, tri-stated serial data out) for the one command that rewrites the whole array with a single word. A free-running system clock runs the block. Chip select, serial clock and data in pass through a synchronizer, and their edges are detected in that domain. Each frame is a start bit, a two-bit opcode and an address field. The opcode and the top two address bits select the command. A write-all frame then carries one data word, most significant bit first.

Once a write-all frame is accepted, a self-timed cycle runs with no further serial clocks. It first sweeps every word of the register-file array to all ones (erase), then sweeps every word again and clears the bits that are zero in the data word (program). The cycle can start on the serial clock edge that samples the last data bit, or on the chip-select fall that follows it; a parameter chooses which. An enable latch, set and cleared by its own frames, must be set for a write-all to run. When chip select is raised again after a cycle starts, the output pin reports busy or ready. A read port exposes the array to neighbouring logic.

Top module: `wa_eeprom_wral`

## Requirements
- R1: After reset the output enable is low, the enable latch is cleared and every array word reads all ones.
- R2: A frame is recognised from its first 1 on DI at a serial clock rise; zeros before it are ignored. It continues with opcode 00 and an address field whose two most significant bits are 01, and then DATA_W data bits, MSB first. This frame is a write-all of that data word.
- R3: With opcode 00, address top bits 11 set the enable latch and 00 clear it, both applied at chip-select fall. A write-all issued while the latch is clear changes no word.
- R4: With CLK_START=0 the cycle starts only at the chip-select fall after the last data bit; while chip select stays high the array is unchanged.
- R5: With CLK_START=1 the cycle starts on the serial clock rise that samples the last data bit and completes with chip select still high and no further serial clock.
- R6: The cycle first sets every word to all ones and then ANDs the data word into every word, so every word ends equal to the data word whatever it held before.
- R7: After a cycle starts, chip select low keeps the output enable low. When chip select is raised again and no start bit has been seen in that frame, the output enable is high and the output is 0 while busy and 1 when ready.
- R8: A frame that receives a start bit and then drops chip select, without starting a cycle, clears the status so later chip-select highs leave the output enable low. A chip-select pulse with no start bit keeps the status.
- R9: If chip select falls before the last data bit, no word changes.
- R10: A write-all, enable or disable frame completed while a cycle is running is ignored.
- R11: A cycle keeps the block busy for exactly CYCLE_LEN system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Serial chip select, active high |
| sclk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value: 0 busy, 1 ready |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |
| mem_addr_i | input | AW | Array read address |
| mem_data_o | output | DATA_W | Array read data |

## Verification
The bench drives two instances, one for each cycle-start mode, from the same serial pins. It holds chip select high after a complete frame: a design that launched on the wrong event would update the array in the wrong instance. It first writes a pattern and then one with other zero bits; a design that skipped the erase sweep would leave the AND of the two. It also aborts a frame mid-data, sends frames while a cycle is still running, and clears the status with a bare start bit. Each of these exposes a design that writes partial data, restarts its cycle, or leaves the busy/ready output driven.

// File: rtl/wa_pkg.sv
package wa_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_PROG, PH_HOLD} phase_e;
  typedef enum logic [1:0] {CMD_NONE, CMD_WRAL, CMD_EWEN, CMD_EWDS} cmd_e;
  typedef enum logic [1:0] {RX_START, RX_HDR, RX_DATA, RX_DONE} rx_e;
endpackage

// File: rtl/wa_sync.sv
module wa_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/wa_frame_rx.sv
module wa_frame_rx
  import wa_pkg::*;
#(
  parameter int ADDR_FIELD_W = 8,
  parameter int DATA_W       = 16,
  parameter bit CLK_START    = 1'b0,
  localparam int HDR_W       = 2 + ADDR_FIELD_W,
  localparam int CNT_MAX     = (HDR_W > DATA_W) ? HDR_W : DATA_W,
  localparam int CW          = $clog2(CNT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              di_i,
  input  logic              busy_i,
  output logic              launch_o,
  output logic [DATA_W-1:0] data_o,
  output logic              start_seen_o,
  output logic              clr_o,
  output logic              wen_o
);
  rx_e               state;
  cmd_e              cmd;
  logic [CW-1:0]     cnt;
  logic [3:0]        hdr;
  logic [3:0]        hdr_nxt;
  logic [DATA_W-1:0] data_q;
  logic              cs_d, sclk_d;
  logic              cs_rise, cs_fall, sclk_rise;
  logic              start_seen, launched, wen;
  logic              launch_q, clr_q;
  logic              go_cs;

  assign cs_rise   = cs_i & ~cs_d;
  assign cs_fall   = ~cs_i & cs_d;
  assign sclk_rise = sclk_i & ~sclk_d;

  // only opcode and the two top address bits matter
  assign hdr_nxt = (cnt < CW'(4)) ? {hdr[2:0], di_i} : hdr;

  assign go_cs = !CLK_START && (state == RX_DONE) && (cmd == CMD_WRAL) && wen && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d       <= 1'b0;
      sclk_d     <= 1'b0;
      state      <= RX_START;
      cmd        <= CMD_NONE;
      cnt        <= '0;
      hdr        <= '0;
      data_q     <= '0;
      start_seen <= 1'b0;
      launched   <= 1'b0;
      wen        <= 1'b0;
      launch_q   <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      cs_d     <= cs_i;
      sclk_d   <= sclk_i;
      launch_q <= 1'b0;
      clr_q    <= 1'b0;
      if (cs_rise) begin
        state      <= RX_START;
        cmd        <= CMD_NONE;
        cnt        <= '0;
        start_seen <= 1'b0;
        launched   <= 1'b0;
      end else if (cs_fall) begin
        state <= RX_START;
        clr_q <= start_seen & ~launched & ~go_cs;
        if (go_cs) launch_q <= 1'b1;
        if (state == RX_DONE && !busy_i) begin
          if (cmd == CMD_EWEN) wen <= 1'b1;
          else if (cmd == CMD_EWDS) wen <= 1'b0;
        end
      end else if (cs_i && sclk_rise) begin
        unique case (state)
          RX_START: begin
            if (di_i) begin
              start_seen <= 1'b1;
              state      <= RX_HDR;
              cnt        <= '0;
            end
          end
          RX_HDR: begin
            hdr <= hdr_nxt;
            if (cnt == CW'(HDR_W - 1)) begin
              cnt   <= '0;
              state <= RX_DONE;
              cmd   <= CMD_NONE;
              if (hdr_nxt[3:2] == 2'b00) begin
                unique case (hdr_nxt[1:0])
                  2'b01: begin cmd <= CMD_WRAL; state <= RX_DATA; end
                  2'b11: cmd <= CMD_EWEN;
                  2'b00: cmd <= CMD_EWDS;
                  default: cmd <= CMD_NONE;
                endcase
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          RX_DATA: begin
            data_q <= {data_q[DATA_W-2:0], di_i};
            if (cnt == CW'(DATA_W - 1)) begin
              state <= RX_DONE;
              if (CLK_START && wen && !busy_i) begin
                launch_q <= 1'b1;
                launched <= 1'b1;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign launch_o     = launch_q;
  assign clr_o        = clr_q;
  assign data_o       = data_q;
  assign start_seen_o = start_seen;
  assign wen_o        = wen;
endmodule

// File: rtl/wa_prog_seq.sv
module wa_prog_seq
  import wa_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DATA_W    = 16,
  parameter int CYCLE_LEN = 64,
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TW       = $clog2(CYCLE_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output phase_e            phase_o,
  output logic              erase_o,
  output logic              prog_o,
  output logic [AW-1:0]     addr_o,
  output logic [DATA_W-1:0] data_o
);
  // CYCLE_LEN must cover both sweeps: CYCLE_LEN >= 2*DEPTH
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  phase_e            phase;
  logic [AW-1:0]     idx;
  logic [TW-1:0]     tcnt;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      tcnt   <= '0;
      word_q <= '0;
    end else if (phase == PH_IDLE) begin
      if (launch_i) begin
        phase  <= PH_ERASE;
        idx    <= '0;
        tcnt   <= '0;
        word_q <= data_i;
      end
    end else begin
      tcnt <= tcnt + TW'(1);
      if (phase == PH_ERASE) begin
        if (idx == LAST) begin idx <= '0; phase <= PH_PROG; end
        else idx <= idx + AW'(1);
      end else if (phase == PH_PROG) begin
        if (idx == LAST) begin idx <= '0; phase <= PH_HOLD; end
        else idx <= idx + AW'(1);
      end
      if (tcnt == TW'(CYCLE_LEN - 1)) phase <= PH_IDLE;
    end
  end

  assign busy_o  = (phase != PH_IDLE);
  assign phase_o = phase;
  assign erase_o = (phase == PH_ERASE);
  assign prog_o  = (phase == PH_PROG);
  assign addr_o  = idx;
  assign data_o  = word_q;
endmodule

// File: rtl/wa_array.sv
module wa_array #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              prog_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[w] <= '1;
      else if (wr_addr_i == AW'(w)) begin
        if (erase_i) mem[w] <= '1;
        else if (prog_i) mem[w] <= mem[w] & wr_data_i;  // program only clears bits
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/wa_eeprom_wral.sv
module wa_eeprom_wral
  import wa_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int DEPTH        = 16,
  parameter int ADDR_FIELD_W = 8,
  parameter int CYCLE_LEN    = 64,
  parameter int SYNC_STAGES  = 2,
  parameter bit CLK_START    = 1'b0,
  localparam int AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              di_i,
  output logic              do_o,
  output logic              do_oe_o,
  input  logic [AW-1:0]     mem_addr_i,
  output logic [DATA_W-1:0] mem_data_o
);
  logic [2:0]        pins_s;
  logic              cs_s, sclk_s, di_s;
  logic              launch, clr, start_seen, wen, busy, armed;
  logic              erase, prog;
  logic [AW-1:0]     wr_addr;
  logic [DATA_W-1:0] rx_data, wr_data;
  phase_e            phase;

  wa_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({di_i, sclk_i, cs_i}),
    .q_o (pins_s)
  );
  assign cs_s   = pins_s[0];
  assign sclk_s = pins_s[1];
  assign di_s   = pins_s[2];

  wa_frame_rx #(.ADDR_FIELD_W(ADDR_FIELD_W), .DATA_W(DATA_W), .CLK_START(CLK_START)) u_rx (
    .clk_i, .rst_ni,
    .cs_i        (cs_s),
    .sclk_i      (sclk_s),
    .di_i        (di_s),
    .busy_i      (busy),
    .launch_o    (launch),
    .data_o      (rx_data),
    .start_seen_o(start_seen),
    .clr_o       (clr),
    .wen_o       (wen)
  );

  wa_prog_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CYCLE_LEN(CYCLE_LEN)) u_seq (
    .clk_i, .rst_ni,
    .launch_i(launch),
    .data_i  (rx_data),
    .busy_o  (busy),
    .phase_o (phase),
    .erase_o (erase),
    .prog_o  (prog),
    .addr_o  (wr_addr),
    .data_o  (wr_data)
  );

  wa_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_arr (
    .clk_i, .rst_ni,
    .erase_i  (erase),
    .prog_i   (prog),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(mem_addr_i),
    .rd_data_o(mem_data_o)
  );

  // status stays armed from cycle start until a start bit is followed by CS low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else if (launch) armed <= 1'b1;
    else if (clr) armed <= 1'b0;
  end

  assign do_oe_o = cs_s & armed & ~start_seen;
  assign do_o    = ~busy;
endmodule

// File: rtl/wa_eeprom_wral_chk.sv
module wa_eeprom_wral_chk
  import wa_pkg::*;
#(
  parameter int CYCLE_LEN = 64
) (
  input logic   clk_i,
  input logic   rst_ni,
  input logic   cs_s,
  input logic   do_oe_o,
  input logic   busy,
  input logic   launch,
  input logic   wen,
  input phase_e phase
);
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else busy_cnt <= 0;
  end

  a_r11_cycle_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> busy_cnt == CYCLE_LEN);

  a_r10_no_launch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !launch);

  a_r3_launch_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |-> wen);

  a_r6_prog_after_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_PROG && $past(phase) != PH_PROG) |-> $past(phase) == PH_ERASE);

  a_r7_oe_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |-> !do_oe_o);
endmodule

bind wa_eeprom_wral wa_eeprom_wral_chk #(.CYCLE_LEN(CYCLE_LEN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_s   (cs_s),
  .do_oe_o(do_oe_o),
  .busy   (busy),
  .launch (launch),
  .wen    (wen),
  .phase  (phase)
);

// File: tb/tb_wa_eeprom_wral.sv
module tb_wa_eeprom_wral;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 50;
  localparam int DATA_W     = 16;
  localparam int DEPTH      = 16;
  localparam int CYC        = 400;
  localparam int AW         = 4;
  localparam int WD_CYCLES  = 150000;
  // vector: {lead zeros[3:0], data[15:0], expected[15:0]}
  localparam logic [35:0] VEC [4] = '{
    {4'd0, 16'h00F0, 16'h00F0},
    {4'd2, 16'h0F0F, 16'h0F0F},
    {4'd0, 16'hA5C3, 16'hA5C3},
    {4'd1, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic do_a, oe_a, do_c, oe_c;
  logic [DATA_W-1:0] mem_a, mem_c;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wa_eeprom_wral #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CYCLE_LEN(CYC), .CLK_START(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
    .do_o(do_a), .do_oe_o(oe_a), .mem_addr_i(mem_addr), .mem_data_o(mem_a));

  wa_eeprom_wral #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CYCLE_LEN(CYC), .CLK_START(1'b1)) dut_c (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
    .do_o(do_c), .do_oe_o(oe_c), .mem_addr_i(mem_addr), .mem_data_o(mem_c));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_mem(input string req, input logic [AW-1:0] a,
                         input logic [15:0] exp_a, input logic [15:0] exp_c);
    mem_addr = a;
    #1;
    chk({req, " cs-mode"}, 32'(mem_a), 32'(exp_a));
    chk({req, " clk-mode"}, 32'(mem_c), 32'(exp_c));
  endtask

  task automatic send_bit(input logic b);
    di = b;
    #HALF sclk = 1'b1;
    #HALF sclk = 1'b0;
  endtask

  // frame: optional leading zeros, n bits MSB first, stop after 'stop' bits if >= 0
  task automatic frame(input logic [31:0] bits, input int n, input int lead,
                       input int stop, input bit drop_cs);
    cs = 1'b1;
    #HALF;
    for (int k = 0; k < lead; k++) send_bit(1'b0);
    for (int i = n - 1; i >= 0; i--) begin
      if (stop >= 0 && (n - 1 - i) == stop) break;
      send_bit(bits[i]);
    end
    if (drop_cs) begin
      cs = 1'b0;
      di = 1'b0;
      #(2*HALF);
    end
  endtask

  function automatic logic [31:0] wral(input logic [15:0] d);
    return {5'd0, 1'b1, 2'b00, 8'h6A, d};
  endfunction

  localparam logic [31:0] EWEN = {21'd0, 1'b1, 2'b00, 8'hC5};
  localparam logic [31:0] EWDS = {21'd0, 1'b1, 2'b00, 8'h15};

  initial begin
    #(WD_CYCLES * CLK_PERIOD);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #3;
    #(5*CLK_PERIOD) rst_n = 1'b1;
    #(5*CLK_PERIOD);

    // R1 reset state
    chk("R1 oe cs-mode", 32'(oe_a), 0);
    chk("R1 oe clk-mode", 32'(oe_c), 0);
    chk_mem("R1 word0", 0, 16'hFFFF, 16'hFFFF);
    chk_mem("R1 word15", 15, 16'hFFFF, 16'hFFFF);

    // R3 write-all with latch clear is ignored
    frame(wral(16'h0000), 27, 0, -1, 1'b1);
    #(5000);
    chk_mem("R3 disabled word0", 0, 16'hFFFF, 16'hFFFF);

    frame(EWEN, 11, 0, -1, 1'b1);

    // R2 / R6 vector walk: every word ends equal to data after erase+program
    foreach (VEC[v]) begin
      frame(wral(VEC[v][31:16]), 27, int'(VEC[v][35:32]), -1, 1'b1);
      #(5000);
      chk_mem("R2 R6 word0", 0, VEC[v][15:0], VEC[v][15:0]);
      chk_mem("R2 R6 word9", 9, VEC[v][15:0], VEC[v][15:0]);
    end

    // R7 R11 R8 status on DO
    frame(wral(16'h1234), 27, 0, -1, 1'b1);
    cs = 1'b1;
    #100;
    chk("R7 oe busy cs-mode", 32'(oe_a), 1);
    chk("R7 do busy cs-mode", 32'(do_a), 0);
    chk("R7 oe busy clk-mode", 32'(oe_c), 1);
    chk("R7 do busy clk-mode", 32'(do_c), 0);
    #3500;
    chk("R11 still busy cs-mode", 32'(do_a), 0);
    chk("R11 still busy clk-mode", 32'(do_c), 0);
    #700;
    chk("R11 ready cs-mode", 32'(do_a), 1);
    chk("R11 ready clk-mode", 32'(do_c), 1);
    cs = 1'b0; #100; cs = 1'b1; #100;
    chk("R8 status kept without start", 32'(oe_a), 1);
    send_bit(1'b1);
    cs = 1'b0; #100; cs = 1'b1; #100;
    chk("R8 cleared cs-mode", 32'(oe_a), 0);
    chk("R8 cleared clk-mode", 32'(oe_c), 0);
    cs = 1'b0; #100;
    chk_mem("R6 word15", 15, 16'h1234, 16'h1234);

    // R4 R5 cycle start event
    frame(wral(16'h5A5A), 27, 0, -1, 1'b0);
    #4500;
    chk_mem("R4 R5 cs held high", 3, 16'h1234, 16'h5A5A);
    cs = 1'b0;
    #4500;
    chk_mem("R4 after cs fall", 3, 16'h5A5A, 16'h5A5A);

    // R9 abort mid-data
    frame(wral(16'h0000), 27, 0, 21, 1'b1);
    #5000;
    chk_mem("R9 aborted frame", 0, 16'h5A5A, 16'h5A5A);

    // R10 frames during a cycle are ignored
    frame(wral(16'h1111), 27, 0, -1, 1'b1);
    frame(wral(16'h2222), 27, 0, -1, 1'b1);
    #5000;
    chk_mem("R10 busy write ignored", 7, 16'h1111, 16'h1111);

    // R3 disable latch then write-all
    frame(EWDS, 11, 0, -1, 1'b1);
    frame(wral(16'h3333), 27, 0, -1, 1'b1);
    #5000;
    chk_mem("R3 after disable", 7, 16'h1111, 16'h1111);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule